// File: doc/BRIEF.md
# Divide-by-three clock generator with synchronous clear

This block turns one fast input clock into a processor clock at one third of its rate and a peripheral clock at half the processor rate. The fast clock comes from one of two pins, an external frequency input or an oscillator reference. A static strap input picks between them. Every register in the block runs on that selected fast clock. The two derived clocks are register outputs, so neither of them can glitch.

A clear input stops the divider so that several generators can be brought into the same phase. The clear first passes through a two-stage synchronizer on the fast clock. While the synchronized clear is active, both derived clocks stay low and the count stays at zero. When the clear is released, the first processor high phase starts at a fixed point. Two units released on the same fast edge therefore produce identical waveforms.

The block also produces an active-high reset output. It follows the inverse of an active-low reset request, which is sampled only at the falling edges of the processor clock.

Top module: `ckgen_top`

## Requirements
- R1: The processor clock repeats every 3 fast-clock cycles and is high for exactly 1 of them.
- R2: The clear input is synchronized through two fast-clock flops. The derived clocks are forced low starting with the third fast edge that sees the clear high. The two edges before that one still follow the normal count.
- R3: While the synchronized clear is active, the processor clock and the peripheral clock both stay low and the divider does not advance.
- R4: After the clear drops, the processor clock first goes high on the third fast edge following the drop, counting the first edge that samples the clear low as edge one.
- R5: The peripheral clock starts low after a clear and toggles on each falling edge of the processor clock. Its period is 6 fast cycles and its duty cycle is 50%.
- R6: Two units whose clears are released on the same fast edge produce identical processor and peripheral clocks. A release that is one cycle later gives a one-cycle phase lag.
- R7: When the source select is 1, the external frequency input drives the divider. When it is 0, the oscillator reference drives it.
- R8: The reset output takes the inverse of the reset request, sampled only at processor-clock falling edges. After the request changes, the output changes at the next falling edge and not before.
- R9: While the clear holds the divider, the reset output does not change, whatever the reset request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| extClkIn | input | 1 | External fast frequency input |
| oscRefIn | input | 1 | Oscillator reference fast clock |
| srcSel | input | 1 | Strap: 1 selects extClkIn, 0 selects oscRefIn |
| syncClearIn | input | 1 | Active-high clear that holds the divider, asynchronous |
| resetReqN | input | 1 | Active-low reset request |
| cpuClkOut | output | 1 | Processor clock: 1/3 rate, one-third duty cycle |
| perClkOut | output | 1 | Peripheral clock: 1/6 rate, 50% duty cycle |
| resetOut | output | 1 | Active-high reset, updated at processor-clock falls |

## Verification
The hardest condition to create is a phase difference between two generators followed by their realignment. Once a divider is running, nothing at the ports shows its count except the waveform. The bench gives each of two instances its own clear. It first releases them one fast cycle apart and checks the one-cycle lag sample by sample. It then clears both and releases them on the same edge, and checks that the waveforms match. The exact synchronizer depth is exposed by asserting the clear at a known point in the count. The bench then checks that the processor high phase falling two edges later still occurs.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

  // Per-cycle strobes from the divider control to the output registers
  typedef struct packed {
    logic hold;         // synchronized clear is active
    logic cpuHighNext;  // processor clock value for the next fast cycle
    logic cpuFall;      // processor clock falls at this edge
  } ckStrobe_t;

endpackage

// File: rtl/ckgen_ctrl.sv
module ckgen_ctrl
  import ckgen_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int HIGH_CYCLES = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      clearIn,
  output ckStrobe_t strobe
);

  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] HIGH_CNT = CNT_W'(HIGH_CYCLES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cnt;
  logic                   hold;

  // Clear synchronizer; the stage count picks the shift structure
  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk) syncQ <= clearIn;
    end else begin : g_sync_chain
      always_ff @(posedge clk) syncQ <= {syncQ[SYNC_STAGES-2:0], clearIn};
    end
  endgenerate

  assign hold = syncQ[SYNC_STAGES-1];

  // Modulo counter; count zero starts the high phase
  always_ff @(posedge clk) begin
    if (hold || cnt == LAST_CNT) cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    strobe.hold        = hold;
    strobe.cpuHighNext = !hold && (cnt < HIGH_CNT);
    strobe.cpuFall     = !hold && (cnt == HIGH_CNT);
  end

endmodule

// File: rtl/ckgen_datapath.sv
module ckgen_datapath
  import ckgen_pkg::*;
(
  input  logic      clk,
  input  ckStrobe_t strobe,
  input  logic      resetReqN,
  output logic      cpuClk,
  output logic      perClk,
  output logic      rstOut
);

  always_ff @(posedge clk) begin
    cpuClk <= strobe.cpuHighNext;
  end

  // Peripheral clock: toggle on processor falls, cleared by hold
  always_ff @(posedge clk) begin
    if (strobe.hold)         perClk <= 1'b0;
    else if (strobe.cpuFall) perClk <= ~perClk;
  end

  // Reset request captured only when the processor clock falls
  always_ff @(posedge clk) begin
    if (strobe.cpuFall) rstOut <= ~resetReqN;
  end

endmodule

// File: rtl/ckgen_top.sv
module ckgen_top
  import ckgen_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int HIGH_CYCLES = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic extClkIn,
  input  logic oscRefIn,
  input  logic srcSel,
  input  logic syncClearIn,
  input  logic resetReqN,
  output logic cpuClkOut,
  output logic perClkOut,
  output logic resetOut
);

  logic      fastClk;
  ckStrobe_t strobe;

  // Static strap choosing the divider source
  assign fastClk = srcSel ? extClkIn : oscRefIn;

  ckgen_ctrl #(
    .DIV_RATIO  (DIV_RATIO),
    .HIGH_CYCLES(HIGH_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk    (fastClk),
    .clearIn(syncClearIn),
    .strobe (strobe)
  );

  ckgen_datapath i_dp (
    .clk      (fastClk),
    .strobe   (strobe),
    .resetReqN(resetReqN),
    .cpuClk   (cpuClkOut),
    .perClk   (perClkOut),
    .rstOut   (resetOut)
  );

endmodule

// File: rtl/ckgen_checker.sv
module ckgen_checker #(
  parameter int DIV_RATIO = 3
) (
  input logic clk,
  input logic holdIn,
  input logic cpuClk,
  input logic perClk,
  input logic rstOut
);

  logic       armed = 1'b0;
  logic       cpuPrev;
  logic       haveRise;
  logic [7:0] sinceRise;

  always_ff @(posedge clk) begin
    if (holdIn) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    cpuPrev <= cpuClk;
    if (holdIn)                 haveRise <= 1'b0;
    else if (cpuClk && !cpuPrev) haveRise <= 1'b1;
    if (cpuClk && !cpuPrev)     sinceRise <= 8'd1;
    else if (sinceRise != 8'hFF) sinceRise <= sinceRise + 8'd1;
  end

  // R1: rises are spaced by the division ratio
  a_r1_period: assert property (@(posedge clk) disable iff (!armed || holdIn)
    (cpuClk && !cpuPrev && haveRise) |-> (sinceRise == 8'(DIV_RATIO)));

  // R3: held divider drives both clocks low
  a_r3_hold_low: assert property (@(posedge clk) disable iff (!armed)
    holdIn |=> (!cpuClk && !perClk));

  // R4: first high phase directly after release
  a_r4_first_high: assert property (@(posedge clk) disable iff (!armed)
    $fell(holdIn) |=> cpuClk);

  // R5: peripheral clock moves only with a processor fall
  a_r5_per_on_fall: assert property (@(posedge clk) disable iff (!armed)
    (!$stable(perClk) && !$past(holdIn)) |-> $fell(cpuClk));

  // R8: reset output moves only with a processor fall
  a_r8_rst_on_fall: assert property (@(posedge clk) disable iff (!armed)
    !$stable(rstOut) |-> $fell(cpuClk));

endmodule

bind ckgen_top ckgen_checker #(.DIV_RATIO(DIV_RATIO)) i_ckgen_checker (
  .clk   (fastClk),
  .holdIn(strobe.hold),
  .cpuClk(cpuClkOut),
  .perClk(perClkOut),
  .rstOut(resetOut)
);

// File: tb/test_ckgen_top.sv
`timescale 1ns/1ps
module test_ckgen_top;

  logic extClk = 1'b0;
  logic oscClk = 1'b0;
  logic srcSelA = 1'b1;
  logic clrA = 1'b1;
  logic clrB = 1'b1;
  logic rstReqN = 1'b1;
  logic cpuA, perA, rstA, cpuB, perB, rstB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 extClk = ~extClk;   // 200 MHz
  always #4   oscClk = ~oscClk;   // 125 MHz alternate source

  ckgen_top i_ckgen_top (
    .extClkIn(extClk), .oscRefIn(oscClk), .srcSel(srcSelA),
    .syncClearIn(clrA), .resetReqN(rstReqN),
    .cpuClkOut(cpuA), .perClkOut(perA), .resetOut(rstA)
  );

  ckgen_top i_ckgen_top_peer (
    .extClkIn(extClk), .oscRefIn(oscClk), .srcSel(1'b1),
    .syncClearIn(clrB), .resetReqN(rstReqN),
    .cpuClkOut(cpuB), .perClkOut(perB), .resetOut(rstB)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected values at the k-th falling edge after a release at a falling edge
  function automatic int expCpu(input int k);
    if (k < 2) return 0;
    return ((k - 2) % 3 == 0) ? 1 : 0;
  endfunction

  function automatic int expPer(input int k);
    if (k < 3) return 0;
    return (((k - 3) / 3) % 2 == 0) ? 1 : 0;
  endfunction

  task automatic holdBoth();
    @(negedge extClk);
    clrA = 1'b1;
    clrB = 1'b1;
    repeat (5) @(negedge extClk);
  endtask

  // R3: reset state while held
  task automatic testHeldState();
    holdBoth();
    chk("R3", "cpu held", int'(cpuA), 0);
    chk("R3", "per held", int'(perA), 0);
    repeat (4) begin
      @(negedge extClk);
      chk("R3", "cpu stays low", int'(cpuA), 0);
    end
  endtask

  // R1, R4, R5, R6: waveform after a joint release
  task automatic testRelease();
    holdBoth();
    clrA = 1'b0;
    clrB = 1'b0;
    for (int k = 0; k < 14; k++) begin
      @(negedge extClk);
      chk((k < 3) ? "R4" : "R1", "cpu pattern", int'(cpuA), expCpu(k));
      chk("R5", "per pattern", int'(perA), expPer(k));
      chk("R6", "peer cpu equal", int'(cpuB), int'(cpuA));
      chk("R6", "peer per equal", int'(perB), int'(perA));
    end
  endtask

  // R6: one-cycle skew, then realignment
  task automatic testSkew();
    holdBoth();
    clrA = 1'b0;
    @(negedge extClk);
    clrB = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge extClk);
      chk("R6", "lead cpu", int'(cpuA), expCpu(k + 1));
      chk("R6", "lag cpu", int'(cpuB), expCpu(k));
      chk("R6", "lag per", int'(perB), expPer(k));
    end
    holdBoth();
    clrA = 1'b0;
    clrB = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge extClk);
      chk("R6", "realigned cpu", int'(cpuB), int'(cpuA));
      chk("R6", "realigned per", int'(perB), int'(perA));
    end
  endtask

  // R2, R3, R9: clear asserted mid-run at a known count
  task automatic testClearDepth();
    int rstKeep;
    holdBoth();
    clrA = 1'b0;
    clrB = 1'b0;
    for (int k = 0; k < 4; k++) @(negedge extClk);
    clrA = 1'b1;                      // at sample k=3
    @(negedge extClk);
    chk("R2", "cpu k4", int'(cpuA), 0);
    chk("R2", "per k4", int'(perA), 1);
    @(negedge extClk);
    chk("R2", "cpu still high k5", int'(cpuA), 1);
    chk("R2", "per k5", int'(perA), 1);
    rstKeep = int'(rstA);
    rstReqN = 1'b0;
    for (int k = 6; k < 14; k++) begin
      @(negedge extClk);
      chk("R3", "cpu forced low", int'(cpuA), 0);
      chk("R3", "per forced low", int'(perA), 0);
      chk("R9", "reset frozen", int'(rstA), rstKeep);
    end
    rstReqN = 1'b1;
    repeat (3) @(negedge extClk);
    chk("R9", "reset frozen after request", int'(rstA), rstKeep);
  endtask

  task automatic waitFall();
    int prev;
    prev = int'(cpuA);
    forever begin
      @(negedge extClk);
      if (prev == 1 && cpuA == 1'b0) break;
      prev = int'(cpuA);
    end
  endtask

  // R8: reset output follows request at processor falls only
  task automatic testResetSync();
    holdBoth();
    clrA = 1'b0;
    clrB = 1'b0;
    waitFall();
    waitFall();
    chk("R8", "idle reset", int'(rstA), 0);
    rstReqN = 1'b0;
    @(negedge extClk);
    chk("R8", "no early assert 1", int'(rstA), 0);
    @(negedge extClk);
    chk("R8", "no early assert 2", int'(rstA), 0);
    @(negedge extClk);
    chk("R8", "assert at fall", int'(rstA), 1);
    chk("R8", "peer assert", int'(rstB), 1);
    waitFall();
    rstReqN = 1'b1;
    @(negedge extClk);
    chk("R8", "no early release 1", int'(rstA), 1);
    @(negedge extClk);
    chk("R8", "no early release 2", int'(rstA), 1);
    @(negedge extClk);
    chk("R8", "release at fall", int'(rstA), 0);
  endtask

  // R7: oscillator source gives 24 ns period and 8 ns high time
  task automatic testOscSource();
    realtime t0, t1, t2;
    clrA = 1'b1;
    srcSelA = 1'b0;
    #100;
    clrA = 1'b0;
    @(posedge cpuA);
    t0 = $realtime;
    @(negedge cpuA);
    t1 = $realtime;
    @(posedge cpuA);
    t2 = $realtime;
    chk("R7", "osc high ns", int'(t1 - t0), 8);
    chk("R7", "osc period ns", int'(t2 - t0), 24);
    clrA = 1'b1;
    srcSelA = 1'b1;
    #100;
    clrA = 1'b0;
    @(posedge cpuA);
    t0 = $realtime;
    @(posedge cpuA);
    t2 = $realtime;
    chk("R7", "ext period ns", int'(t2 - t0), 15);
  endtask

  initial begin
    testHeldState();
    testRelease();
    testSkew();
    testClearDepth();
    testResetSync();
    testOscSource();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge extClk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule